// File: doc/BRIEF.md
# Segment and Page Address Translation Walker

This block turns a 32-bit virtual address into a physical address. The address space has four sections. Each section has a descriptor table base and a last-valid-segment number, which arrive on plain input pins. A request carries the virtual address, an access kind and a fault-check enable. The block first looks in two small direct-mapped caches: one holds segment descriptors and one holds page descriptors. If a descriptor it needs is missing, it reads that descriptor from memory through a word-read port. On a partial miss it fetches only the descriptor that is missing. It then checks bounds, presence and access rights in a fixed order. It ends with a one-cycle done pulse, the physical address or a fault code, and updated fault-address and last-good-address registers.

The request side uses valid/ready. `req_ready_o` is high only while the walker is idle. A request is taken on the first clock edge at which `req_valid_i` and `req_ready_o` are both high. The memory read port also uses valid/ready. `mem_req_valid_o` stays high with a stable `mem_addr_o` until `mem_req_ready_i` accepts it. Only one read is outstanding at a time. The response is taken on the first `mem_rsp_valid_i` after acceptance. The done pulse cannot be stalled, and the caller samples the results while `done_o` is high.

Field layouts:
- Virtual address: section in bits [31:30], segment number in [29:17] and segment offset in [16:0]. For paged segments, the page number is [16:11] and the page offset is [10:0].
- Segment descriptor, word 0: [0] valid, [1] present, [2] contiguous (0 means paged), [3] indirect, [4] trap, [5] cacheable, [7:6] permission, [31:15] size in bytes.
- Segment descriptor, word 1: the segment base for a contiguous segment, or the page table base for a paged segment.
- Page descriptor: [0] present, [1] write-protect, [31:11] frame.

Top module: `segxlate_walker`

## Requirements
- R1: With `xlate_en_i` low, a request completes with `pa_o` equal to the virtual address, no fault and no memory read. It does not change `last_va_o`.
- R2: A segment-descriptor miss whose segment number is greater than the section's last-valid-segment number faults with code 1 and issues no memory read. This holds even when fault checking is off.
- R3: On a segment-descriptor miss, the two descriptor words are read from the section base plus 8 times the segment number and from that address plus 4. A clear valid bit faults with code 2 and an indirect descriptor faults with code 3. Either fault happens after one read.
- R4: A valid descriptor that is not present faults with code 4 for a contiguous segment and code 5 for a paged one. This holds whatever the fault-check enable.
- R5: For a paged segment, the page descriptor is read at word 1 plus 4 times the page number. If 4 times the page number is equal to or greater than the size field, the request faults with code 6.
- R6: Access kinds are encoded as read=0, write=1, fetch=2, fetch-after-discontinuity=3, address-fetch=4, operand-fetch=5, move-translated=6 and interlocked-read=7. Permission 0 allows nothing, permission 1 allows kinds 2 and 3, permission 2 allows kinds 2 to 6, and permission 3 allows all kinds. A denied access faults with code 7, but only when fault checking is on.
- R7: For a contiguous segment, an offset equal to or greater than the size faults with code 8. Otherwise the physical address is word 1 plus the offset. When fault checking is on and the trap bit is set, the request faults with code 9 instead.
- R8: For a paged segment, a non-present page descriptor faults with code 10. With fault checking on, a write or interlocked read to a write-protected page faults with code 11. Otherwise the physical address is the frame joined with the page offset.
- R9: A fault sets `fault_o`, `fault_code_o` and `fault_addr_o`, where `fault_addr_o` takes the virtual address. A successful translation with translation enabled loads `last_va_o`, and a fault leaves it unchanged.
- R10: A segment-descriptor hit issues no memory read. A descriptor is cached only when fault checking is on and its cacheable bit is set, and a page descriptor only when fault checking is on and it is present.
- R11: A hit on the segment descriptor with a miss on the page descriptor reads one word. A hit on the page descriptor with a miss on the segment descriptor reads two words.
- R12: `done_o` is a one-cycle pulse. A memory request holds its address until accepted, and no new request is issued until the response returns.
- R13: The checks run in this order: section length, descriptor valid, indirect, presence, page table length, permission, then offset or page presence, then trap or write-protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en_i | input | 1 | Translation enable; low means identity mapping |
| sect_base_i | input | 128 | Descriptor table base per section, section 0 in the low bits |
| sect_len_i | input | 52 | Last valid segment number per section, 13 bits each |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address |
| req_acc_i | input | 3 | Access kind (R6 encoding) |
| req_fc_i | input | 1 | Fault-check enable |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_addr_o | output | 32 | Memory read word address (byte address) |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address result |
| fault_o | output | 1 | Last request faulted |
| fault_code_o | output | 4 | Fault code (0 = none) |
| fault_addr_o | output | 32 | Virtual address of the last fault |
| last_va_o | output | 32 | Virtual address of the last successful translation |

## Verification
The bench targets the partial-miss paths. A walker that always refetched both descriptors would show extra reads after the segment descriptor was evicted while its page descriptor stayed cached. It also covers the boundary where the offset equals the size and the case where a page index lands exactly at the page table size; an off-by-one would translate instead of faulting. It checks check order by sending a denied access beyond the segment size, which must report a permission fault rather than an offset fault. It also confirms that a length fault still appears with fault checking off. Finally, it runs a cacheable segment with fault checking off and then on, to expose fills that ignore the enable.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

  localparam int VA_W   = 32;
  localparam int SEC_W  = 2;
  localparam int SEG_W  = 13;
  localparam int OFS_W  = 17;
  localparam int PG_W   = 6;
  localparam int POFS_W = 11;
  localparam int NSEC   = 1 << SEC_W;
  localparam int FRM_W  = VA_W - POFS_W;
  localparam int PKEY_W = SEC_W + SEG_W + PG_W;

  typedef enum logic [3:0] {
    FLT_NONE        = 4'd0,
    FLT_SDT_LEN     = 4'd1,
    FLT_SD_INVALID  = 4'd2,
    FLT_SD_INDIRECT = 4'd3,
    FLT_SEG_ABSENT  = 4'd4,
    FLT_PDT_ABSENT  = 4'd5,
    FLT_PDT_LEN     = 4'd6,
    FLT_ACCESS      = 4'd7,
    FLT_SEG_OFS     = 4'd8,
    FLT_OBJ_TRAP    = 4'd9,
    FLT_PAGE_ABSENT = 4'd10,
    FLT_PAGE_WRITE  = 4'd11
  } fault_e;

  typedef enum logic [2:0] {
    ACC_READ       = 3'd0,
    ACC_WRITE      = 3'd1,
    ACC_IFETCH     = 3'd2,
    ACC_IFETCH_AD  = 3'd3,
    ACC_ADDR_FETCH = 3'd4,
    ACC_OPER_FETCH = 3'd5,
    ACC_MOVE_XL    = 3'd6,
    ACC_LOCK_READ  = 3'd7
  } acc_e;

  typedef struct packed {
    logic [OFS_W-1:0] size;
    logic [6:0]       rsvd;
    logic [1:0]       perm;
    logic             cacheable;
    logic             trap;
    logic             indirect;
    logic             contig;
    logic             present;
    logic             valid;
  } sd_word0_t;

  typedef struct packed {
    logic [FRM_W-1:0] frame;
    logic [8:0]       rsvd;
    logic             wprot;
    logic             present;
  } pd_word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SD0, ST_SD1, ST_PD, ST_CHECK, ST_DONE
  } walk_state_e;

endpackage

// File: rtl/segxlate_dmcache.sv
module segxlate_dmcache #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int NENT = 1 << IDX_W;

  logic [NENT-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [NENT];
  logic [DATA_W-1:0] data_q [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = data_q[rd_idx];

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx && rd_tag == wr_tag) |=> rd_hit || !$stable(rd_idx) || !$stable(rd_tag)); // R10

endmodule

// File: rtl/segxlate_perm.sv
module segxlate_perm
  import segxlate_pkg::*;
(
  input  logic [1:0] perm,
  input  acc_e       acc,
  output logic       allow
);
  always_comb begin
    unique case (perm)
      2'd0: allow = 1'b0;
      2'd1: allow = (acc == ACC_IFETCH) || (acc == ACC_IFETCH_AD);
      2'd2: allow = (acc == ACC_IFETCH) || (acc == ACC_IFETCH_AD) ||
                    (acc == ACC_ADDR_FETCH) || (acc == ACC_OPER_FETCH) ||
                    (acc == ACC_MOVE_XL);
      default: allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/segxlate_walker.sv
module segxlate_walker
  import segxlate_pkg::*;
#(
  parameter int SDC_IDX_W = 3,
  parameter int PDC_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xlate_en_i,
  input  logic [NSEC*32-1:0]  sect_base_i,
  input  logic [NSEC*SEG_W-1:0] sect_len_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_va_i,
  input  logic [2:0]          req_acc_i,
  input  logic                req_fc_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [31:0]         mem_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [31:0]         mem_rsp_data_i,
  output logic                done_o,
  output logic [VA_W-1:0]     pa_o,
  output logic                fault_o,
  output logic [3:0]          fault_code_o,
  output logic [VA_W-1:0]     fault_addr_o,
  output logic [VA_W-1:0]     last_va_o
);
  localparam int SDC_IW  = SEC_W + SDC_IDX_W;
  localparam int SDC_TW  = SEG_W - SDC_IDX_W;
  localparam int PDC_TW  = PKEY_W - PDC_IDX_W;

  // ---------------- state ----------------
  walk_state_e state_q, state_d;
  logic [VA_W-1:0] va_q;
  acc_e            acc_q;
  logic            fc_q, pend_q, pd_hit_q, byp_q;
  sd_word0_t       sd0_q;
  logic [31:0]     sd1_q;
  pd_word_t        pd_q;

  // ---------------- field extraction ----------------
  logic [SEC_W-1:0]  in_sec, q_sec;
  logic [SEG_W-1:0]  in_seg, q_seg;
  logic [PG_W-1:0]   in_pg, q_pg;
  logic [OFS_W-1:0]  q_ofs;
  logic [POFS_W-1:0] q_pofs;

  assign in_sec = req_va_i[VA_W-1 -: SEC_W];
  assign in_seg = req_va_i[OFS_W +: SEG_W];
  assign in_pg  = req_va_i[POFS_W +: PG_W];
  assign q_sec  = va_q[VA_W-1 -: SEC_W];
  assign q_seg  = va_q[OFS_W +: SEG_W];
  assign q_pg   = va_q[POFS_W +: PG_W];
  assign q_ofs  = va_q[OFS_W-1:0];
  assign q_pofs = va_q[POFS_W-1:0];

  function automatic logic pdt_over(input sd_word0_t sd, input logic [PG_W-1:0] pg);
    return ({{(OFS_W-PG_W-2){1'b0}}, pg, 2'b00} >= sd.size);
  endfunction

  // ---------------- caches ----------------
  logic              sdc_hit, sdc_wr;
  logic [63:0]       sdc_rdata;
  logic              pdc_hit, pdc_wr;
  logic [31:0]       pdc_rdata;
  logic [PKEY_W-1:0] in_pkey, q_pkey;

  assign in_pkey = {in_sec, in_seg, in_pg};
  assign q_pkey  = {q_sec, q_seg, q_pg};

  segxlate_dmcache #(.IDX_W(SDC_IW), .TAG_W(SDC_TW), .DATA_W(64)) u_sdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  ({in_sec, in_seg[SDC_IDX_W-1:0]}),
    .rd_tag  (in_seg[SEG_W-1:SDC_IDX_W]),
    .rd_hit  (sdc_hit),
    .rd_data (sdc_rdata),
    .wr_en   (sdc_wr),
    .wr_idx  ({q_sec, q_seg[SDC_IDX_W-1:0]}),
    .wr_tag  (q_seg[SEG_W-1:SDC_IDX_W]),
    .wr_data ({mem_rsp_data_i, sd0_q})
  );

  segxlate_dmcache #(.IDX_W(PDC_IDX_W), .TAG_W(PDC_TW), .DATA_W(32)) u_pdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (in_pkey[PDC_IDX_W-1:0]),
    .rd_tag  (in_pkey[PKEY_W-1:PDC_IDX_W]),
    .rd_hit  (pdc_hit),
    .rd_data (pdc_rdata),
    .wr_en   (pdc_wr),
    .wr_idx  (q_pkey[PDC_IDX_W-1:0]),
    .wr_tag  (q_pkey[PKEY_W-1:PDC_IDX_W]),
    .wr_data (mem_rsp_data_i)
  );

  // ---------------- permission ----------------
  logic perm_ok;
  segxlate_perm u_perm (.perm(sd0_q.perm), .acc(acc_q), .allow(perm_ok));

  // ---------------- memory port ----------------
  logic [31:0] sd_addr;
  logic        rsp_take, in_fetch;
  sd_word0_t   rsp_sd0, hit_sd0;
  pd_word_t    rsp_pd;

  assign sd_addr  = sect_base_i[q_sec*32 +: 32] + {{(32-SEG_W-3){1'b0}}, q_seg, 3'b000};
  assign in_fetch = (state_q == ST_SD0) || (state_q == ST_SD1) || (state_q == ST_PD);
  assign mem_req_valid_o = in_fetch && !pend_q;
  assign rsp_take = pend_q && mem_rsp_valid_i;
  assign rsp_sd0  = sd_word0_t'(mem_rsp_data_i);
  assign rsp_pd   = pd_word_t'(mem_rsp_data_i);
  assign hit_sd0  = sd_word0_t'(sdc_rdata[31:0]);

  always_comb begin
    unique case (state_q)
      ST_SD1:  mem_addr_o = sd_addr + 32'd4;
      ST_PD:   mem_addr_o = sd1_q + {{(32-PG_W-2){1'b0}}, q_pg, 2'b00};
      default: mem_addr_o = sd_addr;
    endcase
  end

  // ---------------- walk control ----------------
  logic            fin, fin_byp;
  fault_e          fin_code;
  logic [VA_W-1:0] fin_pa, fin_va;

  assign sdc_wr = (state_q == ST_SD1) && rsp_take && fc_q && sd0_q.cacheable;
  assign pdc_wr = (state_q == ST_PD) && rsp_take && fc_q && rsp_pd.present;

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_byp  = 1'b0;
    fin_code = FLT_NONE;
    fin_pa   = '0;
    fin_va   = va_q;
    unique case (state_q)
      ST_IDLE: begin
        fin_va = req_va_i;
        if (req_valid_i) begin
          if (!xlate_en_i) begin
            fin = 1'b1; fin_byp = 1'b1; fin_pa = req_va_i;
          end else if (!sdc_hit) begin
            if (in_seg > sect_len_i[in_sec*SEG_W +: SEG_W]) begin
              fin = 1'b1; fin_code = FLT_SDT_LEN;
            end else begin
              state_d = ST_SD0;
            end
          end else if (!hit_sd0.contig && !pdc_hit) begin
            if (pdt_over(hit_sd0, in_pg)) begin
              fin = 1'b1; fin_code = FLT_PDT_LEN;
            end else begin
              state_d = ST_PD;
            end
          end else begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_SD0: if (rsp_take) begin
        if (!rsp_sd0.valid) begin
          fin = 1'b1; fin_code = FLT_SD_INVALID;
        end else if (rsp_sd0.indirect) begin
          fin = 1'b1; fin_code = FLT_SD_INDIRECT;
        end else if (!rsp_sd0.present) begin
          fin = 1'b1; fin_code = rsp_sd0.contig ? FLT_SEG_ABSENT : FLT_PDT_ABSENT;
        end else begin
          state_d = ST_SD1;
        end
      end
      ST_SD1: if (rsp_take) begin
        if (!sd0_q.contig && !pd_hit_q) begin
          if (pdt_over(sd0_q, q_pg)) begin
            fin = 1'b1; fin_code = FLT_PDT_LEN;
          end else begin
            state_d = ST_PD;
          end
        end else begin
          state_d = ST_CHECK;
        end
      end
      ST_PD: if (rsp_take) state_d = ST_CHECK;
      ST_CHECK: begin
        fin = 1'b1;
        if (fc_q && !perm_ok) begin
          fin_code = FLT_ACCESS;
        end else if (sd0_q.contig) begin
          if (q_ofs >= sd0_q.size)         fin_code = FLT_SEG_OFS;
          else if (fc_q && sd0_q.trap)     fin_code = FLT_OBJ_TRAP;
          else fin_pa = sd1_q + {{(VA_W-OFS_W){1'b0}}, q_ofs};
        end else begin
          if (!pd_q.present) fin_code = FLT_PAGE_ABSENT;
          else if (fc_q && pd_q.wprot &&
                   (acc_q == ACC_WRITE || acc_q == ACC_LOCK_READ))
            fin_code = FLT_PAGE_WRITE;
          else fin_pa = {pd_q.frame, q_pofs};
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      acc_q        <= ACC_READ;
      fc_q         <= 1'b0;
      pend_q       <= 1'b0;
      pd_hit_q     <= 1'b0;
      byp_q        <= 1'b0;
      sd0_q        <= '0;
      sd1_q        <= '0;
      pd_q         <= '0;
      pa_o         <= '0;
      fault_o      <= 1'b0;
      fault_code_o <= '0;
      fault_addr_o <= '0;
      last_va_o    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        va_q     <= req_va_i;
        acc_q    <= acc_e'(req_acc_i);
        fc_q     <= req_fc_i;
        byp_q    <= !xlate_en_i;
        pd_hit_q <= pdc_hit;
        if (sdc_hit) begin
          sd0_q <= hit_sd0;
          sd1_q <= sdc_rdata[63:32];
        end
        if (pdc_hit) pd_q <= pd_word_t'(pdc_rdata);
      end
      if (mem_req_valid_o && mem_req_ready_i) pend_q <= 1'b1;
      else if (rsp_take)                      pend_q <= 1'b0;
      if (rsp_take) begin
        unique case (state_q)
          ST_SD0:  sd0_q <= rsp_sd0;
          ST_SD1:  sd1_q <= mem_rsp_data_i;
          ST_PD:   pd_q  <= rsp_pd;
          default: ;
        endcase
      end
      if (fin) begin
        pa_o         <= fin_pa;
        fault_o      <= (fin_code != FLT_NONE);
        fault_code_o <= fin_code;
        if (fin_code != FLT_NONE) fault_addr_o <= fin_va;
        else if (!fin_byp)        last_va_o    <= fin_va;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o))); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o); // R12
  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fault_o == (fault_code_o != 4'd0))); // R9
  AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && byp_q) |-> (!fault_o && $stable(last_va_o))); // R1
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_req_valid_o); // R2

endmodule

// File: tb/segxlate_walker_tb_top.sv
module segxlate_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         xlate_en;
  logic [127:0] sect_base;
  logic [51:0]  sect_len;
  logic         req_valid, req_ready, req_fc;
  logic [31:0]  req_va;
  logic [2:0]   req_acc;
  logic         mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0]  mem_addr, mem_rsp_data;
  logic         done, fault;
  logic [31:0]  pa, fault_addr, last_va;
  logic [3:0]   fault_code;

  segxlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .xlate_en_i(xlate_en),
    .sect_base_i(sect_base), .sect_len_i(sect_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_acc_i(req_acc), .req_fc_i(req_fc),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data),
    .done_o(done), .pa_o(pa), .fault_o(fault), .fault_code_o(fault_code),
    .fault_addr_o(fault_addr), .last_va_o(last_va)
  );

  // memory model: ready stalls one cycle in four, response one cycle after accept
  logic [31:0] mem_w [0:1023];
  int unsigned rd_count = 0;
  logic [1:0]  cyc = 2'd0;
  always @(posedge clk) cyc <= cyc + 2'd1;
  assign mem_req_ready = (cyc != 2'd1);
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_w[mem_addr[11:2]];
      rd_count      <= rd_count + 1;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] r_pa;
  logic [3:0]  r_code;
  int          r_reads;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic [2:0] acc, input bit fc);
    int unsigned r0;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_fc = fc;
    while (!req_ready) @(negedge clk);
    r0 = rd_count;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(n < 200, "R12 done timeout", n, 200);
    r_pa = pa; r_code = fault_code; r_reads = int'(rd_count - r0);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] va, input logic [2:0] acc, input bit fc,
                     input logic [3:0] ecode, input logic [31:0] epa,
                     input int ereads, input string rq);
    xlate(va, acc, fc);
    chk(r_code == ecode, {rq, " code"}, r_code, ecode);
    if (ecode == 4'd0) chk(r_pa == epa, {rq, " pa"}, r_pa, epa);
    if (ereads >= 0)   chk(r_reads == ereads, {rq, " reads"}, r_reads, ereads);
  endtask

  function automatic logic [31:0] mk_sd(bit v, bit p, bit c, bit ind, bit tr, bit ca,
                                        logic [1:0] pm, logic [16:0] sz);
    return {sz, 7'd0, pm, ca, tr, ind, c, p, v};
  endfunction

  task automatic put_sd(input int addr, input logic [31:0] w0, input logic [31:0] w1);
    mem_w[addr >> 2] = w0;
    mem_w[(addr >> 2) + 1] = w1;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);
    chk(done == 1'b0 && mem_req_valid == 1'b0, "R12 reset idle", {done, mem_req_valid}, 0);
    chk(fault == 1'b0 && fault_code == 4'd0, "R9 reset fault", fault_code, 0);
  endtask

  task automatic t_bypass();
    xlate_en = 1'b0;
    run(32'h1234_5678, 3'd1, 1'b1, 4'd0, 32'h1234_5678, 0, "R1 bypass");
    chk(last_va == 32'h0, "R1 last_va untouched", last_va, 0);
    xlate_en = 1'b1;
  endtask

  task automatic t_contig();
    run(32'h0000_0010, 3'd5, 1'b1, 4'd0, 32'h8000_0010, 2, "R3 R7 contig miss");
    run(32'h0000_0010, 3'd5, 1'b1, 4'd0, 32'h8000_0010, 0, "R10 sd hit");
    run(32'h0000_0020, 3'd1, 1'b1, 4'd7, 0, 0, "R6 write perm2");
    run(32'h0000_0020, 3'd7, 1'b1, 4'd7, 0, 0, "R6 lockread perm2");
    run(32'h0000_0020, 3'd6, 1'b1, 4'd0, 32'h8000_0020, 0, "R6 movexl perm2");
    run(32'h0000_0020, 3'd1, 1'b0, 4'd0, 32'h8000_0020, 0, "R6 write nocheck");
  endtask

  task automatic t_exec_and_offset();
    run(32'h0002_0040, 3'd0, 1'b1, 4'd7, 0, 2, "R6 read perm1");
    run(32'h0002_0040, 3'd2, 1'b1, 4'd0, 32'h0000_4040, 2, "R6 R10 fetch perm1 uncached");
    run(32'h0002_0040, 3'd0, 1'b0, 4'd0, 32'h0000_4040, 2, "R6 read nocheck");
    run(32'h0002_00FF, 3'd3, 1'b1, 4'd0, 32'h0000_40FF, -1, "R7 last byte");
    run(32'h0002_0100, 3'd2, 1'b1, 4'd8, 0, -1, "R7 offset at size");
    run(32'h0002_0200, 3'd0, 1'b1, 4'd7, 0, -1, "R13 perm before offset");
    run(32'h0002_0200, 3'd0, 1'b0, 4'd8, 0, -1, "R13 offset nocheck");
  endtask

  task automatic t_trap();
    run(32'h0004_0004, 3'd0, 1'b1, 4'd9, 0, 2, "R7 trap");
    run(32'h0004_0004, 3'd0, 1'b0, 4'd0, 32'h0000_5004, 2, "R7 trap nocheck");
  endtask

  task automatic t_sd_faults();
    run(32'h0006_0000, 3'd0, 1'b1, 4'd2, 0, 1, "R3 invalid");
    run(32'h0008_0000, 3'd0, 1'b1, 4'd3, 0, 1, "R3 indirect");
    run(32'h000A_0000, 3'd0, 1'b0, 4'd4, 0, 1, "R4 seg absent");
    run(32'h000C_0000, 3'd0, 1'b1, 4'd5, 0, 1, "R4 pdt absent");
  endtask

  task automatic t_sdt_len();
    run(32'h0020_0000, 3'd0, 1'b1, 4'd1, 0, 0, "R2 seg 16");
    run(32'h0020_0000, 3'd0, 1'b0, 4'd1, 0, 0, "R2 nocheck");
    run(32'h4006_0000, 3'd0, 1'b1, 4'd1, 0, 0, "R2 sec1 seg3");
    run(32'h4004_0000, 3'd0, 1'b1, 4'd2, 0, 1, "R2 sec1 seg2 in range");
  endtask

  task automatic t_paged();
    run(32'h000E_0123, 3'd5, 1'b1, 4'd0, 32'h0001_0123, 3, "R5 R8 paged miss");
    run(32'h000E_0123, 3'd5, 1'b1, 4'd0, 32'h0001_0123, 0, "R10 both hit");
    run(32'h000E_1807, 3'd0, 1'b1, 4'd0, 32'h0002_0007, 1, "R11 pd only");
    run(32'h000E_0800, 3'd1, 1'b1, 4'd11, 0, 1, "R8 write wprot");
    run(32'h000E_0800, 3'd7, 1'b1, 4'd11, 0, 0, "R8 lockread wprot");
    run(32'h000E_0804, 3'd1, 1'b0, 4'd0, 32'h0003_0004, 0, "R8 write nocheck");
    run(32'h000E_0804, 3'd0, 1'b1, 4'd0, 32'h0003_0004, 0, "R8 read wprot");
    run(32'h000E_1000, 3'd0, 1'b0, 4'd10, 0, 1, "R8 page absent");
    run(32'h000E_2000, 3'd0, 1'b1, 4'd6, 0, 0, "R5 pdt len");
  endtask

  task automatic t_pd_hit_sd_miss();
    run(32'h001E_0008, 3'd5, 1'b1, 4'd0, 32'h0000_9008, 2, "R10 evict seg7");
    run(32'h000E_0123, 3'd5, 1'b1, 4'd0, 32'h0001_0123, 2, "R11 sd only");
  endtask

  task automatic t_fill_suppress();
    run(32'h4000_0010, 3'd0, 1'b0, 4'd0, 32'h0000_A010, 2, "R10 nocheck miss");
    run(32'h4000_0010, 3'd0, 1'b0, 4'd0, 32'h0000_A010, 2, "R10 nocheck no fill");
    run(32'h4000_0010, 3'd0, 1'b1, 4'd0, 32'h0000_A010, 2, "R10 check fill");
    run(32'h4000_0010, 3'd0, 1'b1, 4'd0, 32'h0000_A010, 0, "R10 check hit");
  endtask

  task automatic t_fault_regs();
    run(32'h0000_0030, 3'd5, 1'b1, 4'd0, 32'h8000_0030, 0, "R9 success");
    chk(last_va == 32'h0000_0030, "R9 last_va", last_va, 32'h30);
    chk(fault == 1'b0, "R9 fault flag clear", fault, 0);
    run(32'h0020_0004, 3'd0, 1'b1, 4'd1, 0, 0, "R9 fault");
    chk(fault == 1'b1, "R9 fault flag", fault, 1);
    chk(fault_addr == 32'h0020_0004, "R9 fault_addr", fault_addr, 32'h0020_0004);
    chk(last_va == 32'h0000_0030, "R9 last_va kept", last_va, 32'h30);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem_w[i] = 32'h0;
    sect_base = {32'h0, 32'h0, 32'h0000_0200, 32'h0000_0100};
    sect_len  = {13'd0, 13'd0, 13'd2, 13'd15};
    put_sd(32'h100 + 8*0,  mk_sd(1,1,1,0,0,1,2'd2,17'h1000), 32'h8000_0000);
    put_sd(32'h100 + 8*1,  mk_sd(1,1,1,0,0,0,2'd1,17'h0100), 32'h0000_4000);
    put_sd(32'h100 + 8*2,  mk_sd(1,1,1,0,1,0,2'd3,17'h1000), 32'h0000_5000);
    put_sd(32'h100 + 8*3,  mk_sd(0,1,1,0,0,0,2'd3,17'h1000), 32'h0000_6000);
    put_sd(32'h100 + 8*4,  mk_sd(1,1,1,1,0,0,2'd3,17'h1000), 32'h0000_6000);
    put_sd(32'h100 + 8*5,  mk_sd(1,0,1,0,0,0,2'd3,17'h1000), 32'h0000_6000);
    put_sd(32'h100 + 8*6,  mk_sd(1,0,0,0,0,0,2'd3,17'h0010), 32'h0000_0300);
    put_sd(32'h100 + 8*7,  mk_sd(1,1,0,0,0,1,2'd3,17'h0010), 32'h0000_0300);
    put_sd(32'h100 + 8*15, mk_sd(1,1,1,0,0,1,2'd3,17'h1000), 32'h0000_9000);
    put_sd(32'h200,        mk_sd(1,1,1,0,0,1,2'd3,17'h0800), 32'h0000_A000);
    mem_w[(32'h300 >> 2) + 0] = 32'h0001_0001;
    mem_w[(32'h300 >> 2) + 1] = 32'h0003_0003;
    mem_w[(32'h300 >> 2) + 2] = 32'h0004_0000;
    mem_w[(32'h300 >> 2) + 3] = 32'h0002_0001;
    xlate_en = 1'b1; req_valid = 1'b0; req_va = '0; req_acc = '0; req_fc = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_contig();
    t_exec_and_offset();
    t_trap();
    t_sd_faults();
    t_sdt_len();
    t_paged();
    t_pd_hit_sd_miss();
    t_fill_suppress();
    t_fault_regs();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule